// File: doc/BRIEF.md
# Multi-Bus Result Broadcast Arbiter

This block decides, every cycle, which finished results from six functional-unit classes go out on the shared common data buses, of which there are a build-time number. Each class presents a valid flag, a destination tag and a 32-bit result word. The arbiter ranks the classes by a fixed order and grants as many buses as it has. The branch class holds top rank, then divide, load/store, multiply, floating-point add and finally integer ALU. Branch outcomes go out on a bus like any other result.

Grants return on a per-unit ready line in the same cycle as the request, which gives a valid/ready handshake for each unit. A unit that is not granted keeps its request and payload steady and tries again on the next cycle. The winners are packed onto buses 0 upward with no gaps, in rank order. The buses are registered, so a granted result is broadcast one cycle after its grant. Each bus carries its own busy flag.

Top module: `cdb_broadcast_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, every bus valid flag is low and every bus tag and data field is zero.
- R2: Requester index 0 is the branch unit, 1 divide, 2 load/store, 3 multiply, 4 FP add and 5 integer ALU. When some requester is left ungranted, no requester with a higher index is granted in that cycle.
- R3: The number of grants in a cycle equals the smaller of NUM_BUS and the number of asserted request valids. The units left out are always the lowest-ranked ones.
- R4: Bus k is given to the k-th granted requester counted from index 0. Busy buses form a contiguous group starting at bus 0.
- R5: req_ready[i] is asserted only when req_valid[i] is asserted. A unit is placed on at most one bus per cycle.
- R6: The tag and data of a unit granted in cycle t appear on its assigned bus, with the bus valid flag high, in cycle t+1.
- R7: A bus that receives no grant in cycle t shows valid low and tag and data zero in cycle t+1.
- R8: A unit whose request is not granted keeps req_valid, tag and data stable into the next cycle. It is granted in a later cycle once fewer higher-ranked units contend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 6 | Per-unit result-ready request, index 0 is highest rank |
| req_tag | input | 6*TAG_W | Per-unit destination tag |
| req_data | input | 6*DATA_W | Per-unit result word |
| req_ready | output | 6 | Per-unit grant, same cycle as the request |
| bus_valid | output | NUM_BUS | Per-bus busy flag |
| bus_tag | output | NUM_BUS*TAG_W | Per-bus broadcast tag |
| bus_data | output | NUM_BUS*DATA_W | Per-bus broadcast data |

## Verification
A wrong rank count inside the arbiter shows up at once on req_ready in the same cycle, as a missing, extra or out-of-order grant. One cycle later the same fault shows on the buses as a gap in the busy flags or a tag on the wrong bus. A fault in a bus slot register shows up one cycle after the grant: the payload is stale or not zero, or it belongs to another unit. A broken hold path appears as a low-ranked unit that is never granted across a drain sequence.

// File: rtl/cdb_arb_pkg.sv
package cdb_arb_pkg;

  localparam int NUM_CLASS = 6;
  localparam int RANK_W    = $clog2(NUM_CLASS + 1);

  // number of set bits strictly below position idx
  function automatic logic [RANK_W-1:0] ones_below(input logic [NUM_CLASS-1:0] v, input int idx);
    logic [RANK_W-1:0] c;
    c = '0;
    for (int j = 0; j < NUM_CLASS; j++) begin
      if (j < idx && v[j]) c = c + 1'b1;
    end
    return c;
  endfunction

  function automatic logic [RANK_W-1:0] ones_all(input logic [NUM_CLASS-1:0] v);
    return ones_below(v, NUM_CLASS);
  endfunction

  function automatic logic [RANK_W-1:0] capped(input logic [RANK_W-1:0] c, input int lim);
    return (int'(c) > lim) ? RANK_W'(lim) : c;
  endfunction

  // index of lowest set bit, NUM_CLASS when empty
  function automatic int lowest_set(input logic [NUM_CLASS-1:0] v);
    int r;
    r = NUM_CLASS;
    for (int j = NUM_CLASS - 1; j >= 0; j--) begin
      if (v[j]) r = j;
    end
    return r;
  endfunction

  // index of highest set bit, -1 when empty
  function automatic int highest_set(input logic [NUM_CLASS-1:0] v);
    int r;
    r = -1;
    for (int j = 0; j < NUM_CLASS; j++) begin
      if (v[j]) r = j;
    end
    return r;
  endfunction

endpackage

// File: rtl/cdb_rank_unit.sv
module cdb_rank_unit
  import cdb_arb_pkg::*;
#(
  parameter int NUM_BUS = 3
) (
  input  logic [NUM_CLASS-1:0]             valid,
  output logic [NUM_CLASS-1:0]             grant,
  output logic [NUM_CLASS-1:0][RANK_W-1:0] rank
);

  // each requester's rank is the count of active requesters above it
  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_rank
    assign rank[i]  = ones_below(valid, i);
    assign grant[i] = valid[i] && (int'(rank[i]) < NUM_BUS);
  end

endmodule

// File: rtl/cdb_bus_slot.sv
module cdb_bus_slot
  import cdb_arb_pkg::*;
#(
  parameter int SLOT   = 0,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CLASS-1:0]             grant,
  input  logic [NUM_CLASS-1:0][RANK_W-1:0] rank,
  input  logic [NUM_CLASS-1:0][TAG_W-1:0]  req_tag,
  input  logic [NUM_CLASS-1:0][DATA_W-1:0] req_data,
  output logic                             bus_valid,
  output logic [TAG_W-1:0]                 bus_tag,
  output logic [DATA_W-1:0]                bus_data
);

  logic [NUM_CLASS-1:0] sel;
  logic                 taken;
  logic [TAG_W-1:0]     mux_tag;
  logic [DATA_W-1:0]    mux_data;

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_sel
    assign sel[i] = grant[i] && (rank[i] == RANK_W'(SLOT));
  end

  assign taken = |sel;

  always_comb begin
    mux_tag  = '0;
    mux_data = '0;
    for (int i = 0; i < NUM_CLASS; i++) begin
      if (sel[i]) begin
        mux_tag  = mux_tag  | req_tag[i];
        mux_data = mux_data | req_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_tag   <= '0;
      bus_data  <= '0;
    end else begin
      bus_valid <= taken;
      bus_tag   <= mux_tag;
      bus_data  <= mux_data;
    end
  end

  // at most one unit drives this bus (R5)
  assert_one_winner_per_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // a claimed slot shows busy next cycle (R6)
  assert_busy_after_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> bus_valid);

  // an unclaimed slot goes idle and zero (R7)
  assert_idle_is_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> (!bus_valid && bus_tag == '0 && bus_data == '0));

endmodule

// File: rtl/cdb_broadcast_arbiter.sv
module cdb_broadcast_arbiter
  import cdb_arb_pkg::*;
#(
  parameter int NUM_BUS = 3,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CLASS-1:0]             req_valid,
  input  logic [NUM_CLASS-1:0][TAG_W-1:0]  req_tag,
  input  logic [NUM_CLASS-1:0][DATA_W-1:0] req_data,
  output logic [NUM_CLASS-1:0]             req_ready,
  output logic [NUM_BUS-1:0]               bus_valid,
  output logic [NUM_BUS-1:0][TAG_W-1:0]    bus_tag,
  output logic [NUM_BUS-1:0][DATA_W-1:0]   bus_data
);

  logic [NUM_CLASS-1:0]             grant;
  logic [NUM_CLASS-1:0][RANK_W-1:0] rank;
  logic [NUM_CLASS-1:0]             blocked;
  logic [RANK_W-1:0]                grant_count;
  logic [RANK_W-1:0]                want_count;

  cdb_rank_unit #(.NUM_BUS(NUM_BUS)) u_rank (
    .valid (req_valid),
    .grant (grant),
    .rank  (rank)
  );

  for (genvar k = 0; k < NUM_BUS; k++) begin : g_bus
    cdb_bus_slot #(.SLOT(k), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant),
      .rank      (rank),
      .req_tag   (req_tag),
      .req_data  (req_data),
      .bus_valid (bus_valid[k]),
      .bus_tag   (bus_tag[k]),
      .bus_data  (bus_data[k])
    );
  end

  assign req_ready   = grant;
  assign blocked     = req_valid & ~grant;
  assign grant_count = ones_all(grant);
  assign want_count  = capped(ones_all(req_valid), NUM_BUS);

  // ready only for a requesting unit (R5)
  assert_ready_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // grants fill all buses that requests can use (R3)
  assert_grant_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_count == want_count);

  // every granted index lies above every blocked index (R2)
  assert_rank_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked != '0) |-> (highest_set(grant) < lowest_set(blocked)));

  // busy buses are packed from bus 0 (R4)
  assert_buses_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_valid & (bus_valid + 1'b1)) == '0));

  // one busy bus per grant of the previous cycle (R6)
  assert_bus_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(bus_valid) == $past($countones(req_ready))));

  // a waiting unit holds its request steady (R8)
  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_hold
    assert_hold_until_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && !req_ready[i]) |=>
        (req_valid[i] && $stable(req_tag[i]) && $stable(req_data[i])));
  end

endmodule

// File: tb/cdb_broadcast_arbiter_bench.sv
`timescale 1ns/1ps
module cdb_broadcast_arbiter_bench;

  localparam int NC = 6;
  localparam int NB = 3;
  localparam int TW = 6;
  localparam int DW = 32;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NC-1:0]          req_valid = '0;
  logic [NC-1:0][TW-1:0]  req_tag = '0;
  logic [NC-1:0][DW-1:0]  req_data = '0;
  logic [NC-1:0]          req_ready;
  logic [NB-1:0]          bus_valid;
  logic [NB-1:0][TW-1:0]  bus_tag;
  logic [NB-1:0][DW-1:0]  bus_data;

  int n_chk = 0;
  int n_bad = 0;

  cdb_broadcast_arbiter #(.NUM_BUS(NB), .TAG_W(TW), .DATA_W(DW)) u_cdb_broadcast_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_data(req_data), .req_ready(req_ready), .bus_valid(bus_valid),
    .bus_tag(bus_tag), .bus_data(bus_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // walk units from rank 0 downward, handing out buses in order
  function automatic logic [NC-1:0] expect_grant(input logic [NC-1:0] v);
    logic [NC-1:0] g;
    int used;
    g = '0;
    used = 0;
    for (int i = 0; i < NC; i++) begin
      if (v[i] && used < NB) begin
        g[i] = 1'b1;
        used++;
      end
    end
    return g;
  endfunction

  task automatic load(input int unit, input int salt);
    req_tag[unit]  = TW'(unit * 8 + (salt % 8));
    req_data[unit] = 32'hC0DE_0000 | (32'(unit) << 12) | 32'(salt);
  endtask

  // one cycle: drive at falling edge, check ready, then the buses a cycle later
  task automatic step(input logic [NC-1:0] v, input string req, output logic [NC-1:0] g);
    logic [NB-1:0]         ev;
    logic [NB-1:0][TW-1:0] et;
    logic [NB-1:0][DW-1:0] ed;
    int k;
    req_valid = v;
    #1;
    g = expect_grant(v);
    chk(req_ready === g, {req, " R2 R3 ready"}, 64'(req_ready), 64'(g));
    chk((req_ready & ~v) == '0, "R5 ready without valid", 64'(req_ready), 64'(v));
    ev = '0; et = '0; ed = '0; k = 0;
    for (int i = 0; i < NC; i++) begin
      if (g[i]) begin
        ev[k] = 1'b1; et[k] = req_tag[i]; ed[k] = req_data[i];
        k++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      chk(bus_valid[b] === ev[b], {req, " R4 R7 bus valid"}, 64'(bus_valid[b]), 64'(ev[b]));
      chk(bus_tag[b]   === et[b], {req, " R6 R7 bus tag"},   64'(bus_tag[b]),   64'(et[b]));
      chk(bus_data[b]  === ed[b], {req, " R6 R7 bus data"},  64'(bus_data[b]),  64'(ed[b]));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_valid === '0, "R1 valid in reset", 64'(bus_valid), 0);
    chk(bus_tag === '0 && bus_data === '0, "R1 payload in reset", 64'(bus_data[0]), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(bus_valid === '0, "R1 valid after reset", 64'(bus_valid), 0);
    chk(req_ready === '0, "R5 idle ready", 64'(req_ready), 0);
  endtask

  task automatic t_single_each();
    logic [NC-1:0] g;
    for (int i = 0; i < NC; i++) begin
      load(i, i + 1);
      step(NC'(1) << i, "single R4 R6", g);
    end
  endtask

  task automatic t_all_contend();
    logic [NC-1:0] v;
    logic [NC-1:0] g;
    for (int i = 0; i < NC; i++) load(i, 3);
    v = '1;
    step(v, "full R3", g);
    chk(g == 6'b000111, "R2 top three first", 64'(g), 64'h07);
    v = v & ~g;  // waiting units keep payload (R8)
    step(v, "retry R8", g);
    chk(g == 6'b111000, "R8 waiting units granted", 64'(g), 64'h38);
    v = v & ~g;
    chk(v == '0, "R8 drained", 64'(v), 0);
  endtask

  task automatic t_gap();
    logic [NC-1:0] g;
    load(1, 5);
    load(5, 6);
    step(6'b100010, "gap R4", g);
    chk(bus_tag[1] === req_tag[5], "R4 second bus gets ALU", 64'(bus_tag[1]), 64'(req_tag[5]));
  endtask

  task automatic t_branch_stream();
    logic [NC-1:0] pend;
    logic [NC-1:0] g;
    int alu_cycle;
    pend = 6'b111000;
    load(3, 1); load(4, 2); load(5, 4);
    alu_cycle = -1;
    for (int c = 0; c < 4; c++) begin
      load(0, c);
      load(1, c + 2);
      step(pend | 6'b000011, "stream R2", g);
      if (g[5] && alu_cycle < 0) alu_cycle = c;
      pend = pend & ~g;
    end
    // each cycle two buses go to branch and divide, the third to one waiting unit
    chk(alu_cycle == 2, "R8 ALU served after MUL and FP", 64'(alu_cycle), 2);
  endtask

  task automatic t_idle();
    logic [NC-1:0] g;
    load(2, 7);
    step(6'b000100, "one then idle R7", g);
    step('0, "idle R7", g);
    chk(bus_valid === '0, "R7 all idle", 64'(bus_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single_each();
    t_all_contend();
    t_gap();
    t_branch_stream();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule